// File: doc/BRIEF.md
# Random Word Readout Port

This block is the software-facing end of a random-number path. An internal producer hands over 128-bit blocks of generated data, each tagged with a compliance flag, through a valid/ready handshake. The block holds one block at a time and lets software take it out as four 32-bit words through a single data register that is read again and again. A status pair tells software whether a block is waiting and whether that block carries the compliance flag.

Data reads are open only while two multi-bit enables both carry their true codes: a 4-bit software enable field and an 8-bit enable coming from one-time-programmable fuses. Any other code closes the port, and a closed port returns zero without consuming data. Each accepted block is also compared with the block accepted before it; an exact repeat sets a sticky recoverable-alert status bit and emits a one-cycle event for the alert sender. Software clears the status bit by writing zero to it.

Top module: `rng_word_port`

## Requirements
- R1: After reset the data-available and compliance status bits are 0, the producer ready output is 1, the repeat alert status is 0 and the data output is 0.
- R2: When the producer presents valid data while ready is 1, the block is taken at that clock edge; in the next cycle data-available is 1 and ready is 0, and further valid blocks are not taken until the block is drained.
- R3: Words come out least significant first: the k-th read of a block (k = 0..3) returns block bits [32k+31:32k], and the data output shows the word the next read will consume.
- R4: Exactly four reads drain a block; after the edge of the fourth read data-available is 0 and ready is 1 again, never earlier.
- R5: While no block is held the data output is 0 and a read strobe has no effect: the next block still starts with its lowest word.
- R6: The data output is 0 unless the software enable equals 4'h6 and the fuse enable equals 8'h96; every other value of either input (including the false code 4'h9) closes the port.
- R7: A read strobe while the port is closed does not advance the word position; once reopened the same word is returned.
- R8: A block accepted with exactly the value of the previously accepted block sets the repeat alert status in the next cycle and raises the alert event output for that one cycle; the first block after reset never raises it.
- R9: The repeat alert status stays 1 until an alert write with data 0; an alert write with data 1 leaves it unchanged, and a new repeat in the same cycle as a clearing write leaves it set.
- R10: The compliance status equals the flag given with the held block and reads 0 whenever no block is held.
- R11: A sequence of N blocks is emptied by exactly 4N reads, with each block accepted only after the previous one is drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| blk_valid_i | input | 1 | Producer has a block ready |
| blk_data_i | input | 128 | Generated block |
| blk_cert_i | input | 1 | Compliance flag of the block |
| blk_ready_o | output | 1 | Port can accept a block |
| sw_en_i | input | 4 | Software enable field (true 4'h6, false 4'h9) |
| fuse_en_i | input | 8 | Fuse enable (true 8'h96) |
| rd_strobe_i | input | 1 | Software read of the data register |
| rd_data_o | output | 32 | Data register value |
| sts_avail_o | output | 1 | A block is held |
| sts_cert_o | output | 1 | Held block is compliance-flagged |
| alert_wr_i | input | 1 | Write to the repeat alert status bit |
| alert_wdata_i | input | 1 | Data of that write (0 clears) |
| rep_alert_o | output | 1 | Sticky repeat alert status |
| rep_event_o | output | 1 | One-cycle repeat alert event |

## Verification
A block taken at edge t shows as available, with ready low and its lowest word on the data output, from just after edge t, and the alert status and event of a repeat appear in that same cycle; the event is gone after edge t+1. The data output is combinational on held state and enables, so a read strobe held across edge t changes the word or the status bits just after that edge. The bench drives every input on the falling edge and samples every output on the falling edge that follows the edge it expects to act, so each check reads a settled value exactly one register stage after its stimulus.

// File: rtl/rng_port_pkg.sv
package rng_port_pkg;

    localparam logic [3:0] MB4_TRUE  = 4'h6;
    localparam logic [3:0] MB4_FALSE = 4'h9;
    localparam logic [7:0] MB8_TRUE  = 8'h96;

endpackage

// File: rtl/rng_port_gate.sv
module rng_port_gate
    import rng_port_pkg::*;
(
    input  logic [3:0] sw_en_i,
    input  logic [7:0] fuse_en_i,
    output logic       open_o
);

    logic sw_on;
    logic fuse_on;

    always_comb begin
        sw_on   = (sw_en_i == MB4_TRUE);
        fuse_on = (fuse_en_i == MB8_TRUE);
        open_o  = sw_on & fuse_on;
    end

endmodule

// File: rtl/rng_port_seq.sv
module rng_port_seq #(
    parameter int BLK_W  = 128,
    parameter int WORD_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              blk_valid_i,
    input  logic [BLK_W-1:0]  blk_data_i,
    input  logic              blk_cert_i,
    input  logic              rd_req_i,
    output logic              blk_ready_o,
    output logic              accept_o,
    output logic              avail_o,
    output logic              cert_o,
    output logic [WORD_W-1:0] word_o
);

    localparam int NWORDS = BLK_W / WORD_W;
    localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1);

    typedef struct packed {
        logic [BLK_W-1:0] blk;
        logic             avail;
        logic             cert;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t st_d, st_q;
    logic take;

    always_comb begin
        st_d = st_q;
        take = blk_valid_i & ~st_q.avail;
        if (take) begin
            st_d.blk   = blk_data_i;
            st_d.avail = 1'b1;
            st_d.cert  = blk_cert_i;
            st_d.idx   = '0;
        end else if (rd_req_i && st_q.avail) begin
            if (st_q.idx == LAST_IDX) begin
                st_d.avail = 1'b0;
                st_d.cert  = 1'b0;
                st_d.idx   = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign blk_ready_o = ~st_q.avail;
    assign accept_o    = take;
    assign avail_o     = st_q.avail;
    assign cert_o      = st_q.cert;
    assign word_o      = st_q.blk[st_q.idx*WORD_W +: WORD_W];

endmodule

// File: rtl/rng_port_cmp.sv
module rng_port_cmp #(
    parameter int BLK_W = 128
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             accept_i,
    input  logic [BLK_W-1:0] data_i,
    input  logic             clr_i,
    output logic             alert_o,
    output logic             event_o
);

    typedef struct packed {
        logic [BLK_W-1:0] prev;
        logic             prev_vld;
        logic             alert;
        logic             evt;
    } cmp_t;

    cmp_t st_d, st_q;
    logic same;

    always_comb begin
        st_d     = st_q;
        same     = accept_i && st_q.prev_vld && (data_i == st_q.prev);
        st_d.evt = same;
        if (clr_i) begin
            st_d.alert = 1'b0;
        end
        if (same) begin
            st_d.alert = 1'b1;
        end
        if (accept_i) begin
            st_d.prev     = data_i;
            st_d.prev_vld = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alert_o = st_q.alert;
    assign event_o = st_q.evt;

endmodule

// File: rtl/rng_word_port.sv
module rng_word_port #(
    parameter int BLK_W  = 128,
    parameter int WORD_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              blk_valid_i,
    input  logic [BLK_W-1:0]  blk_data_i,
    input  logic              blk_cert_i,
    output logic              blk_ready_o,
    input  logic [3:0]        sw_en_i,
    input  logic [7:0]        fuse_en_i,
    input  logic              rd_strobe_i,
    output logic [WORD_W-1:0] rd_data_o,
    output logic              sts_avail_o,
    output logic              sts_cert_o,
    input  logic              alert_wr_i,
    input  logic              alert_wdata_i,
    output logic              rep_alert_o,
    output logic              rep_event_o
);

    logic              port_open;
    logic              accept;
    logic              avail;
    logic [WORD_W-1:0] word;

    rng_port_gate i_gate (
        .sw_en_i   (sw_en_i),
        .fuse_en_i (fuse_en_i),
        .open_o    (port_open)
    );

    rng_port_seq #(
        .BLK_W  (BLK_W),
        .WORD_W (WORD_W)
    ) i_seq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .blk_valid_i (blk_valid_i),
        .blk_data_i  (blk_data_i),
        .blk_cert_i  (blk_cert_i),
        .rd_req_i    (rd_strobe_i & port_open),
        .blk_ready_o (blk_ready_o),
        .accept_o    (accept),
        .avail_o     (avail),
        .cert_o      (sts_cert_o),
        .word_o      (word)
    );

    rng_port_cmp #(
        .BLK_W (BLK_W)
    ) i_cmp (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .accept_i (accept),
        .data_i   (blk_data_i),
        .clr_i    (alert_wr_i & ~alert_wdata_i),
        .alert_o  (rep_alert_o),
        .event_o  (rep_event_o)
    );

    assign sts_avail_o = avail;
    assign rd_data_o   = (port_open && avail) ? word : '0;

endmodule

// File: rtl/rng_word_port_chk.sv
module rng_word_port_chk #(
    parameter int BLK_W  = 128,
    parameter int WORD_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              blk_valid_i,
    input logic              blk_ready_o,
    input logic [3:0]        sw_en_i,
    input logic [7:0]        fuse_en_i,
    input logic              rd_strobe_i,
    input logic [WORD_W-1:0] rd_data_o,
    input logic              sts_avail_o,
    input logic              sts_cert_o,
    input logic              alert_wr_i,
    input logic              alert_wdata_i,
    input logic              rep_alert_o,
    input logic              rep_event_o
);

    p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (blk_valid_i && blk_ready_o) |=> (sts_avail_o && !blk_ready_o));

    p_hold_until_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sts_avail_o && !rd_strobe_i) |=> sts_avail_o);

    p_idle_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sts_avail_o |-> (rd_data_o == '0));

    p_gate_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(sw_en_i == 4'h6 && fuse_en_i == 8'h96) |-> (rd_data_o == '0));

    p_event_sets_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rep_event_o |-> rep_alert_o);

    p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rep_alert_o && !(alert_wr_i && !alert_wdata_i)) |=> rep_alert_o);

    p_cert_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sts_avail_o |-> !sts_cert_o);

endmodule

bind rng_word_port rng_word_port_chk #(
    .BLK_W  (BLK_W),
    .WORD_W (WORD_W)
) i_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .blk_valid_i   (blk_valid_i),
    .blk_ready_o   (blk_ready_o),
    .sw_en_i       (sw_en_i),
    .fuse_en_i     (fuse_en_i),
    .rd_strobe_i   (rd_strobe_i),
    .rd_data_o     (rd_data_o),
    .sts_avail_o   (sts_avail_o),
    .sts_cert_o    (sts_cert_o),
    .alert_wr_i    (alert_wr_i),
    .alert_wdata_i (alert_wdata_i),
    .rep_alert_o   (rep_alert_o),
    .rep_event_o   (rep_event_o)
);

// File: tb/test_rng_word_port.sv
module test_rng_word_port;

    localparam int CLK_PERIOD = 10;
    localparam int BLK_W      = 128;
    localparam int WORD_W     = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              blk_valid = 1'b0;
    logic [BLK_W-1:0]  blk_data = '0;
    logic              blk_cert = 1'b0;
    logic              blk_ready;
    logic [3:0]        sw_en = 4'h6;
    logic [7:0]        fuse_en = 8'h96;
    logic              rd_strobe = 1'b0;
    logic [WORD_W-1:0] rd_data;
    logic              sts_avail;
    logic              sts_cert;
    logic              alert_wr = 1'b0;
    logic              alert_wdata = 1'b0;
    logic              rep_alert;
    logic              rep_event;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rng_word_port #(.BLK_W(BLK_W), .WORD_W(WORD_W)) i_rng_word_port (
        .clk_i(clk), .rst_ni(rst_n),
        .blk_valid_i(blk_valid), .blk_data_i(blk_data), .blk_cert_i(blk_cert),
        .blk_ready_o(blk_ready), .sw_en_i(sw_en), .fuse_en_i(fuse_en),
        .rd_strobe_i(rd_strobe), .rd_data_o(rd_data),
        .sts_avail_o(sts_avail), .sts_cert_o(sts_cert),
        .alert_wr_i(alert_wr), .alert_wdata_i(alert_wdata),
        .rep_alert_o(rep_alert), .rep_event_o(rep_event)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] wv(input int n, input int k);
        return 32'(n * 4 + k + 1) * 32'h9E3779B1;
    endfunction

    function automatic logic [BLK_W-1:0] mk(input int n);
        logic [BLK_W-1:0] b;
        for (int k = 0; k < 4; k++) b[k*32 +: 32] = wv(n, k);
        return b;
    endfunction

    // present a block for one edge; optionally write the alert bit in the same cycle
    task automatic push(input int n, input bit cert, input bit wr, input bit wd);
        blk_valid = 1'b1; blk_data = mk(n); blk_cert = cert;
        alert_wr = wr; alert_wdata = wd;
        @(posedge clk); @(negedge clk);
        blk_valid = 1'b0; alert_wr = 1'b0; alert_wdata = 1'b0;
    endtask

    task automatic rd_word(input logic [31:0] exp, input string req);
        chk(rd_data === exp, req, rd_data, exp);
        rd_strobe = 1'b1;
        @(posedge clk); @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic drain(input int n);
        for (int k = 0; k < 4; k++) begin
            chk(sts_avail === 1'b1, "R4 avail before last read", 32'(sts_avail), 32'd1);
            rd_word(wv(n, k), "R3 word order");
        end
        chk(sts_avail === 1'b0, "R4 avail after fourth read", 32'(sts_avail), 32'd0);
        chk(blk_ready === 1'b1, "R4 ready after fourth read", 32'(blk_ready), 32'd1);
    endtask

    task automatic wr_alert(input bit wd);
        alert_wr = 1'b1; alert_wdata = wd;
        @(posedge clk); @(negedge clk);
        alert_wr = 1'b0; alert_wdata = 1'b0;
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(sts_avail === 1'b0, "R1 avail", 32'(sts_avail), 0);
        chk(sts_cert === 1'b0, "R1 cert", 32'(sts_cert), 0);
        chk(blk_ready === 1'b1, "R1 ready", 32'(blk_ready), 1);
        chk(rep_alert === 1'b0, "R1 alert", 32'(rep_alert), 0);
        chk(rd_data === '0, "R1 data", rd_data, 0);

        // R5: read with nothing held
        rd_word(32'd0, "R5 idle read zero");
        chk(sts_avail === 1'b0, "R5 idle read no effect", 32'(sts_avail), 0);

        // R11 / R2 / R10 / R8: six distinct blocks, 24 reads
        for (int n = 0; n < 6; n++) begin
            push(n, n[0], 1'b0, 1'b0);
            chk(sts_avail === 1'b1 && blk_ready === 1'b0, "R2 accepted", {sts_avail, blk_ready}, 32'b10);
            chk(sts_cert === n[0], "R10 cert flag", 32'(sts_cert), 32'(n[0]));
            chk(rep_event === 1'b0 && rep_alert === 1'b0, "R8 no repeat", {rep_event, rep_alert}, 0);
            // R2: producer offering a different block while full is not taken
            blk_valid = 1'b1; blk_data = mk(100);
            @(posedge clk); @(negedge clk);
            blk_valid = 1'b0;
            chk(rd_data === wv(n, 0), "R2 full ignores producer", rd_data, wv(n, 0));
            drain(n);
            chk(sts_cert === 1'b0, "R10 cert cleared", 32'(sts_cert), 0);
        end

        // R5: first block after idle reads still starts at word 0
        rd_word(32'd0, "R5 idle read zero");
        push(7, 1'b1, 1'b0, 1'b0);
        chk(rd_data === wv(7, 0), "R5 counter untouched", rd_data, wv(7, 0));

        // R6 / R7: sweep all software codes against several fuse codes
        rd_word(wv(7, 0), "R3 word0");
        for (int s = 0; s < 16; s++) begin
            for (int f = 0; f < 4; f++) begin
                logic [7:0] fv;
                fv = (f == 0) ? 8'h96 : (f == 1) ? 8'h69 : (f == 2) ? 8'h00 : 8'h97;
                sw_en = 4'(s); fuse_en = fv;
                @(negedge clk);
                if (s == 6 && f == 0) begin
                    chk(rd_data === wv(7, 1), "R6 open", rd_data, wv(7, 1));
                end else begin
                    rd_word(32'd0, "R6 closed reads zero");
                end
            end
        end
        sw_en = 4'h6; fuse_en = 8'h96;
        @(negedge clk);
        chk(rd_data === wv(7, 1), "R7 closed reads did not advance", rd_data, wv(7, 1));
        chk(sts_avail === 1'b1, "R7 still held", 32'(sts_avail), 1);
        for (int k = 1; k < 4; k++) rd_word(wv(7, k), "R3 word order");
        chk(sts_avail === 1'b0, "R4 drained", 32'(sts_avail), 0);

        // R8: repeat of block 7
        push(7, 1'b0, 1'b0, 1'b0);
        chk(rep_event === 1'b1, "R8 event pulse", 32'(rep_event), 1);
        chk(rep_alert === 1'b1, "R8 alert set", 32'(rep_alert), 1);
        @(negedge clk);
        chk(rep_event === 1'b0, "R8 event one cycle", 32'(rep_event), 0);
        drain(7);

        // R9: write of one keeps it, new distinct block keeps it
        wr_alert(1'b1);
        chk(rep_alert === 1'b1, "R9 write one no effect", 32'(rep_alert), 1);
        push(8, 1'b0, 1'b0, 1'b0);
        chk(rep_alert === 1'b1 && rep_event === 1'b0, "R9 sticky", {rep_event, rep_alert}, 1);
        drain(8);
        wr_alert(1'b0);
        chk(rep_alert === 1'b0, "R9 write zero clears", 32'(rep_alert), 0);

        // R9: repeat and clear in the same cycle, set wins
        push(8, 1'b0, 1'b1, 1'b0);
        chk(rep_alert === 1'b1, "R9 set beats clear", 32'(rep_alert), 1);
        drain(8);
        wr_alert(1'b0);
        chk(rep_alert === 1'b0, "R9 cleared again", 32'(rep_alert), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule